// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block sits between a host request port and an 8-bit multiplexed NAND flash bus. The host hands over one operation at a time: page read, page program, block erase, status read, identifier read or device reset. The block expands that request into the exact run of command, address and data bus cycles the flash expects. It drives the latch strobes with widths taken from run-time timing inputs counted in system clocks. It also waits for the ready/busy line wherever the flash has internal work to finish.

Every byte written to the flash goes out on the shared I/O bus. The block holds chip enable low and raises either the command-latch or the address-latch line, or neither for data, then pulses the write strobe. Read data comes back by pulsing the read strobe, and each byte is presented to the host with a one-cycle valid flag. Program data is pulled from the host one byte per bus cycle through a take pulse. A busy wait that outlasts a programmable limit ends the request with a timeout flag.

Top module: `nand_host_seq`

## Requirements
- R1: After reset and whenever no request is in progress, `reqReady` is 1, `nandCeN`, `nandWeN` and `nandReN` are 1, and `nandCle`, `nandAle` and `doneP` are 0.
- R2: Each written byte is latched on a rising edge of `nandWeN` while `nandCeN` is 0. For a command byte `nandCle`=1 and `nandAle`=0, for an address byte `nandAle`=1 and `nandCle`=0, and for a data byte both are 0. `nandDq` and both latch lines are unchanged across that edge.
- R3: Each bus cycle holds its latch lines with the strobe high for max(`cfgSetup`,1) clocks. It then drives `nandWeN` (write) or `nandReN` (read) low for max(`cfgLow`,1) clocks and high for max(`cfgHigh`,1) clocks. The two strobes are never low together.
- R4: Page read sends command 00h when `reqCol` < 256, 01h when 256 ≤ `reqCol` < 512, and 50h when `reqCol` ≥ 512. This is followed by four address bytes in this order: `reqCol[7:0]`, `reqRow[7:0]`, `reqRow[15:8]`, and {7'b0, `reqRow[16]`}.
- R5: After the read address, the block waits for `nandRb` to go low and then high. It then performs `reqCount` read cycles and returns each byte on `rdData`, with `rdValid` high for one clock, in bus order. `nandDqOe` is 0 while `nandReN` is low.
- R6: Page program sends the same pointer command and four address bytes as R4, with command 80h between them. It then writes `reqCount` data bytes, each taken from `wrData` in the clock where `wrTake` is 1. After that it sends command 10h and waits out busy as in R5.
- R7: Block erase sends command 60h, then the three row bytes of R4 (no column byte), then command D0h, and waits out busy.
- R8: Status read sends command 70h and performs exactly one read cycle whatever `reqCount` holds, with no busy wait.
- R9: Identifier read sends command 90h, one address byte 00h, then `reqCount` read cycles.
- R10: Reset sends command FFh and waits out busy.
- R11: If a busy wait lasts longer than `cfgTimeout` clocks, the request ends with `timedOut`=1 together with `doneP`, and no further bus cycle of that request is performed. Otherwise `timedOut` is 0 at `doneP`.
- R12: A request is accepted in a clock with `reqValid` and `reqReady` both high. `reqReady` then stays 0 and `nandCeN` stays 0 until a single `doneP` pulse, after which `reqReady` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSetup | input | 4 | Latch-line setup time before a strobe falls, in clocks |
| cfgLow | input | 4 | Strobe low width, in clocks |
| cfgHigh | input | 4 | Strobe high width, in clocks |
| cfgTimeout | input | 16 | Busy-wait limit, in clocks |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request accepted when valid |
| reqOp | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 identifier, 5 reset |
| reqRow | input | 17 | Page (row) address |
| reqCol | input | 10 | Column within the page, 0 to 527 |
| reqCount | input | 10 | Number of data bytes to move |
| wrData | input | 8 | Program data byte |
| wrTake | output | 1 | Current `wrData` is consumed at this clock edge |
| rdData | output | 8 | Byte read from the flash |
| rdValid | output | 1 | `rdData` valid for one clock |
| doneP | output | 1 | One-clock pulse at the end of a request |
| timedOut | output | 1 | Busy wait exceeded the limit, valid with `doneP` |
| nandCeN | output | 1 | Flash chip enable, active low |
| nandCle | output | 1 | Command latch line |
| nandAle | output | 1 | Address latch line |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandRb | input | 1 | Flash ready (1) / busy (0) |
| nandDq | output | 8 | Byte driven toward the flash |
| nandDqOe | output | 1 | Output enable for `nandDq` |
| nandDqIn | input | 8 | Byte returned by the flash |

## Verification
The properties assume that `nandRb` is the only input that moves on its own. The host inputs only change while `reqReady` is low or at a new request. The flash model holds `nandRb` low for long enough that the sequencer can see it low after its post-command delay. The bench keeps the busy pulse at least 20 clocks long and starts it a few clocks after the triggering write-strobe edge. It also presents returned bytes on the falling read strobe, well before the sampling clock. Random requests draw legal columns (below 528), 17-bit rows and small byte counts, and the timing inputs are drawn in 0 to 3. Only the directed timeout case holds busy past `cfgTimeout`.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  localparam int BYTE_W = 8;

  // host operation codes
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_STATUS = 3'd3,
    OP_ID     = 3'd4,
    OP_RESET  = 3'd5
  } nandOp_t;

  // kind of a single bus cycle
  typedef enum logic [1:0] {
    K_CMD  = 2'd0,
    K_ADDR = 2'd1,
    K_WR   = 2'd2,
    K_RD   = 2'd3
  } busKind_t;

  // kind of a step in an operation script
  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_WR, ST_RD, ST_WAIT, ST_END
  } stepKind_t;

  typedef struct packed {
    stepKind_t          kind;
    logic [BYTE_W-1:0]  val;
  } step_t;

  // control -> datapath strobes
  typedef struct packed {
    logic               go;
    busKind_t           kind;
    logic [BYTE_W-1:0]  dout;
    logic               waitGo;
    logic               ceOn;
  } seqStrobe_t;

  localparam logic [BYTE_W-1:0] CMD_RD_LO    = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_RD_HI    = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_RD_SPARE = 8'h50;
  localparam logic [BYTE_W-1:0] CMD_PG_SETUP = 8'h80;
  localparam logic [BYTE_W-1:0] CMD_PG_GO    = 8'h10;
  localparam logic [BYTE_W-1:0] CMD_ER_SETUP = 8'h60;
  localparam logic [BYTE_W-1:0] CMD_ER_GO    = 8'hD0;
  localparam logic [BYTE_W-1:0] CMD_STATUS   = 8'h70;
  localparam logic [BYTE_W-1:0] CMD_IDENT    = 8'h90;
  localparam logic [BYTE_W-1:0] CMD_RESET    = 8'hFF;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int ROW_W = 17,
  parameter int COL_W = 10,
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              cycDone,
  input  logic              waitDone,
  input  logic              waitTimeout,
  output seqStrobe_t        strobe,
  output logic              wrTake,
  output logic              doneP,
  output logic              timedOut
);

  localparam int IDX_W  = 4;
  localparam int ROWX_W = 3 * BYTE_W;

  typedef enum logic [2:0] {C_IDLE, C_STEP, C_CYC, C_WAIT, C_FIN} ctrlState_t;

  ctrlState_t        state;
  logic [2:0]        opQ;
  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic [CNT_W-1:0]  leftQ;
  logic [IDX_W-1:0]  idxQ;
  logic              toQ;
  step_t             stepNow;

  // script of one operation: step idx -> what to put on the bus
  function automatic step_t stepAt(input logic [2:0] op, input logic [IDX_W-1:0] idx,
                                   input logic [COL_W-1:0] col, input logic [ROW_W-1:0] row);
    step_t s;
    logic [BYTE_W-1:0] ptr;
    logic [ROWX_W-1:0] rowX;
    rowX = ROWX_W'(row);
    ptr  = col[9] ? CMD_RD_SPARE : (col[8] ? CMD_RD_HI : CMD_RD_LO);
    s    = '{ST_END, '0};
    case (op)
      OP_READ: case (idx)
        4'd0: s = '{ST_CMD,  ptr};
        4'd1: s = '{ST_ADDR, col[7:0]};
        4'd2: s = '{ST_ADDR, rowX[7:0]};
        4'd3: s = '{ST_ADDR, rowX[15:8]};
        4'd4: s = '{ST_ADDR, rowX[23:16]};
        4'd5: s = '{ST_WAIT, '0};
        4'd6: s = '{ST_RD,   '0};
        default: s = '{ST_END, '0};
      endcase
      OP_PROG: case (idx)
        4'd0: s = '{ST_CMD,  ptr};
        4'd1: s = '{ST_CMD,  CMD_PG_SETUP};
        4'd2: s = '{ST_ADDR, col[7:0]};
        4'd3: s = '{ST_ADDR, rowX[7:0]};
        4'd4: s = '{ST_ADDR, rowX[15:8]};
        4'd5: s = '{ST_ADDR, rowX[23:16]};
        4'd6: s = '{ST_WR,   '0};
        4'd7: s = '{ST_CMD,  CMD_PG_GO};
        4'd8: s = '{ST_WAIT, '0};
        default: s = '{ST_END, '0};
      endcase
      OP_ERASE: case (idx)
        4'd0: s = '{ST_CMD,  CMD_ER_SETUP};
        4'd1: s = '{ST_ADDR, rowX[7:0]};
        4'd2: s = '{ST_ADDR, rowX[15:8]};
        4'd3: s = '{ST_ADDR, rowX[23:16]};
        4'd4: s = '{ST_CMD,  CMD_ER_GO};
        4'd5: s = '{ST_WAIT, '0};
        default: s = '{ST_END, '0};
      endcase
      OP_STATUS: case (idx)
        4'd0: s = '{ST_CMD, CMD_STATUS};
        4'd1: s = '{ST_RD,  '0};
        default: s = '{ST_END, '0};
      endcase
      OP_ID: case (idx)
        4'd0: s = '{ST_CMD,  CMD_IDENT};
        4'd1: s = '{ST_ADDR, '0};
        4'd2: s = '{ST_RD,   '0};
        default: s = '{ST_END, '0};
      endcase
      OP_RESET: case (idx)
        4'd0: s = '{ST_CMD,  CMD_RESET};
        4'd1: s = '{ST_WAIT, '0};
        default: s = '{ST_END, '0};
      endcase
      default: s = '{ST_END, '0};
    endcase
    return s;
  endfunction

  always_comb begin
    stepNow     = stepAt(opQ, idxQ, colQ, rowQ);
    strobe      = '0;
    strobe.ceOn = (state != C_IDLE);
    if (state == C_STEP) begin
      case (stepNow.kind)
        ST_CMD:  begin strobe.go = 1'b1; strobe.kind = K_CMD;  strobe.dout = stepNow.val; end
        ST_ADDR: begin strobe.go = 1'b1; strobe.kind = K_ADDR; strobe.dout = stepNow.val; end
        ST_WR:   begin strobe.go = (leftQ != '0); strobe.kind = K_WR; end
        ST_RD:   begin strobe.go = (leftQ != '0); strobe.kind = K_RD; end
        ST_WAIT: strobe.waitGo = 1'b1;
        default: ;
      endcase
    end
  end

  assign reqReady = (state == C_IDLE);
  assign doneP    = (state == C_FIN);
  assign timedOut = (state == C_FIN) && toQ;
  assign wrTake   = strobe.go && (strobe.kind == K_WR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= C_IDLE;
      opQ   <= '0;
      rowQ  <= '0;
      colQ  <= '0;
      leftQ <= '0;
      idxQ  <= '0;
      toQ   <= 1'b0;
    end else begin
      case (state)
        C_IDLE: if (reqValid) begin
          opQ   <= reqOp;
          rowQ  <= reqRow;
          colQ  <= reqCol;
          leftQ <= (reqOp == OP_STATUS) ? CNT_W'(1) : reqCount;
          idxQ  <= '0;
          toQ   <= 1'b0;
          state <= C_STEP;
        end
        C_STEP: case (stepNow.kind)
          ST_CMD, ST_ADDR: state <= C_CYC;
          ST_WR, ST_RD: begin
            if (leftQ == '0) idxQ <= idxQ + 1'b1;
            else begin
              leftQ <= leftQ - 1'b1;
              state <= C_CYC;
            end
          end
          ST_WAIT: state <= C_WAIT;
          default: state <= C_FIN;
        endcase
        C_CYC: if (cycDone) begin
          if (stepNow.kind == ST_CMD || stepNow.kind == ST_ADDR) idxQ <= idxQ + 1'b1;
          state <= C_STEP;
        end
        C_WAIT: begin
          if (waitTimeout) begin
            toQ   <= 1'b1;
            state <= C_FIN;
          end else if (waitDone) begin
            idxQ  <= idxQ + 1'b1;
            state <= C_STEP;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int TIM_W = 4,
  parameter int TO_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic [TIM_W-1:0]   cfgSetup,
  input  logic [TIM_W-1:0]   cfgLow,
  input  logic [TIM_W-1:0]   cfgHigh,
  input  logic [TO_W-1:0]    cfgTimeout,
  output logic               cycDone,
  output logic               waitDone,
  output logic               waitTimeout,
  output logic [BYTE_W-1:0]  rdData,
  output logic               rdValid,
  output logic               nandCeN,
  output logic               nandCle,
  output logic               nandAle,
  output logic               nandWeN,
  output logic               nandReN,
  input  logic               nandRb,
  output logic [BYTE_W-1:0]  nandDq,
  output logic               nandDqOe,
  input  logic [BYTE_W-1:0]  nandDqIn
);

  localparam int SYNC_N = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_LOW, PH_HIGH} phase_t;
  typedef enum logic [1:0] {W_OFF, W_LOW, W_HIGH} waitPh_t;

  phase_t             phase;
  busKind_t           kindQ;
  logic [BYTE_W-1:0]  byteQ;
  logic [TIM_W-1:0]   tCnt;
  waitPh_t            wPh;
  logic [TO_W-1:0]    wCnt;
  logic [SYNC_N-1:0]  rbSync;
  logic               rbNow;

  // a width of zero is treated as one clock
  function automatic logic [TIM_W-1:0] loadOf(input logic [TIM_W-1:0] w);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  // bus cycle engine
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      kindQ   <= K_CMD;
      byteQ   <= '0;
      tCnt    <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
      cycDone <= 1'b0;
    end else begin
      rdValid <= 1'b0;
      cycDone <= 1'b0;
      case (phase)
        PH_IDLE: if (strobe.go) begin
          kindQ <= strobe.kind;
          byteQ <= (strobe.kind == K_WR) ? wrData : strobe.dout;
          tCnt  <= loadOf(cfgSetup);
          phase <= PH_SETUP;
        end
        PH_SETUP: begin
          if (tCnt == '0) begin
            tCnt  <= loadOf(cfgLow);
            phase <= PH_LOW;
          end else tCnt <= tCnt - 1'b1;
        end
        PH_LOW: begin
          if (tCnt == '0) begin
            tCnt  <= loadOf(cfgHigh);
            phase <= PH_HIGH;
            if (kindQ == K_RD) begin
              rdData  <= nandDqIn;
              rdValid <= 1'b1;
            end
          end else tCnt <= tCnt - 1'b1;
        end
        default: begin
          if (tCnt == '0) begin
            phase   <= PH_IDLE;
            cycDone <= 1'b1;
          end else tCnt <= tCnt - 1'b1;
        end
      endcase
    end
  end

  // ready/busy synchroniser and busy wait with limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rbSync      <= '1;
      wPh         <= W_OFF;
      wCnt        <= '0;
      waitDone    <= 1'b0;
      waitTimeout <= 1'b0;
    end else begin
      rbSync      <= {rbSync[SYNC_N-2:0], nandRb};
      waitDone    <= 1'b0;
      waitTimeout <= 1'b0;
      case (wPh)
        W_OFF: if (strobe.waitGo) begin
          wCnt <= '0;
          wPh  <= W_LOW;
        end
        default: begin
          wCnt <= wCnt + 1'b1;
          if (wPh == W_HIGH && rbNow) begin
            waitDone <= 1'b1;
            wPh      <= W_OFF;
          end else if (wCnt >= cfgTimeout) begin
            waitTimeout <= 1'b1;
            wPh         <= W_OFF;
          end else if (wPh == W_LOW && !rbNow) begin
            wPh <= W_HIGH;
          end
        end
      endcase
    end
  end

  assign rbNow    = rbSync[SYNC_N-1];
  assign nandCeN  = !strobe.ceOn;
  assign nandCle  = (phase != PH_IDLE) && (kindQ == K_CMD);
  assign nandAle  = (phase != PH_IDLE) && (kindQ == K_ADDR);
  assign nandWeN  = !((phase == PH_LOW) && (kindQ != K_RD));
  assign nandReN  = !((phase == PH_LOW) && (kindQ == K_RD));
  assign nandDq   = byteQ;
  assign nandDqOe = (phase != PH_IDLE) && (kindQ != K_RD);

endmodule

// File: rtl/nand_host_seq.sv
module nand_host_seq
  import nand_seq_pkg::*;
#(
  parameter int ROW_W = 17,
  parameter int COL_W = 10,
  parameter int CNT_W = 10,
  parameter int TIM_W = 4,
  parameter int TO_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIM_W-1:0]  cfgSetup,
  input  logic [TIM_W-1:0]  cfgLow,
  input  logic [TIM_W-1:0]  cfgHigh,
  input  logic [TO_W-1:0]   cfgTimeout,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        reqOp,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [7:0]        wrData,
  output logic              wrTake,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              doneP,
  output logic              timedOut,
  output logic              nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  input  logic              nandRb,
  output logic [7:0]        nandDq,
  output logic              nandDqOe,
  input  logic [7:0]        nandDqIn
);

  seqStrobe_t strobe;
  logic       cycDone;
  logic       waitDone;
  logic       waitTimeout;

  nand_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqRow(reqRow), .reqCol(reqCol), .reqCount(reqCount),
    .cycDone(cycDone), .waitDone(waitDone), .waitTimeout(waitTimeout),
    .strobe(strobe), .wrTake(wrTake), .doneP(doneP), .timedOut(timedOut)
  );

  nand_seq_dp #(.TIM_W(TIM_W), .TO_W(TO_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cfgSetup(cfgSetup), .cfgLow(cfgLow), .cfgHigh(cfgHigh), .cfgTimeout(cfgTimeout),
    .cycDone(cycDone), .waitDone(waitDone), .waitTimeout(waitTimeout),
    .rdData(rdData), .rdValid(rdValid),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandRb(nandRb),
    .nandDq(nandDq), .nandDqOe(nandDqOe), .nandDqIn(nandDqIn)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqReady,
  input logic       doneP,
  input logic       rdValid,
  input logic       nandCeN,
  input logic       nandCle,
  input logic       nandAle,
  input logic       nandWeN,
  input logic       nandReN,
  input logic [7:0] nandDq,
  input logic       nandDqOe
);

  AST_IDLE_CE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> nandCeN); // R1

  AST_ONE_LATCH_LINE: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R2

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> !nandCeN); // R2

  AST_HOLD_AT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> ($stable(nandDq) && $stable(nandCle) && $stable(nandAle))); // R2

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R3

  AST_READ_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDqOe); // R5

  AST_READ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!nandReN)); // R5

  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    doneP |=> reqReady); // R12

endmodule

bind nand_host_seq nand_seq_chk uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .doneP(doneP), .rdValid(rdValid),
  .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
  .nandReN(nandReN), .nandDq(nandDq), .nandDqOe(nandDqOe)
);

// File: tb/sim_nand_host_seq.sv
`timescale 1ns/1ps
module sim_nand_host_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgSetup = 4'd1, cfgLow = 4'd1, cfgHigh = 4'd1;
  logic [15:0] cfgTimeout = 16'd4000;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [2:0]  reqOp = '0;
  logic [16:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic [9:0]  reqCount = '0;
  logic [7:0]  wrData = '0;
  logic        wrTake;
  logic [7:0]  rdData;
  logic        rdValid, doneP, timedOut;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN;
  logic        nandRb = 1'b1;
  logic [7:0]  nandDq;
  logic        nandDqOe;
  logic [7:0]  nandDqIn = '0;

  always #2.5 clk = ~clk;

  nand_host_seq u0 (
    .clk(clk), .rstN(rstN), .cfgSetup(cfgSetup), .cfgLow(cfgLow), .cfgHigh(cfgHigh),
    .cfgTimeout(cfgTimeout), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqRow(reqRow), .reqCol(reqCol), .reqCount(reqCount), .wrData(wrData), .wrTake(wrTake),
    .rdData(rdData), .rdValid(rdValid), .doneP(doneP), .timedOut(timedOut),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandRb(nandRb), .nandDq(nandDq), .nandDqOe(nandDqOe),
    .nandDqIn(nandDqIn)
  );

  int errors = 0, checks = 0, cyc = 0;
  int busyLen = 24;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdPat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction
  function automatic logic [7:0] wrPat(input int i);
    return 8'(i * 13 + 5);
  endfunction

  // flash model: log latched bytes as {cle, ale, byte}
  logic [9:0] logE [0:1023];
  int logN = 0, busyFires = 0, busyServed = 0, addrCnt = 0;
  logic [7:0] lastCmd = 8'h00;
  always @(posedge nandWeN) begin
    if (!nandCeN && logN < 1024) begin
      logE[logN] = {nandCle, nandAle, nandDq};
      logN++;
      if (nandCle) begin
        lastCmd = nandDq;
        addrCnt = 0;
        if (nandDq == 8'h10 || nandDq == 8'hD0 || nandDq == 8'hFF) busyFires++;
      end else if (nandAle) begin
        addrCnt++;
        if ((lastCmd == 8'h00 || lastCmd == 8'h01 || lastCmd == 8'h50) && addrCnt == 4) busyFires++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (busyFires != busyServed) begin
      busyServed = busyFires;
      repeat (3) @(negedge clk);
      nandRb = 1'b0;
      repeat (busyLen) @(negedge clk);
      nandRb = 1'b1;
    end
  end

  int rdIdx = 0;
  always @(negedge nandReN) begin
    nandDqIn = rdPat(rdIdx);
    rdIdx++;
  end

  // host-side capture, strobe width measurement and write data supply
  logic [7:0] gotRd [0:1023];
  int gotN = 0, wIdx = 0;
  int weRun = 0, reRun = 0, suRun = 0;
  int weMin = 99, weMax = 0, reMin = 99, reMax = 0, suMin = 99, suMax = 0;
  always @(negedge clk) begin
    cyc++;
    if (rdValid && gotN < 1024) begin gotRd[gotN] = rdData; gotN++; end
    wrData = wrPat(wIdx);
    if (wrTake) wIdx++;
    if (!nandWeN) weRun++;
    else if (weRun != 0) begin
      if (weRun < weMin) weMin = weRun;
      if (weRun > weMax) weMax = weRun;
      weRun = 0;
    end
    if (!nandReN) reRun++;
    else if (reRun != 0) begin
      if (reRun < reMin) reMin = reRun;
      if (reRun > reMax) reMax = reRun;
      reRun = 0;
    end
    if (!(nandCle || nandAle)) suRun = 0;
    else if (nandWeN) suRun++;
    else if (suRun != 0) begin
      if (suRun < suMin) suMin = suRun;
      if (suRun > suMax) suMax = suRun;
      suRun = 0;
    end
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // expected bus frame
  logic [9:0] expE [0:1023];
  int expN;
  task automatic put(input logic [1:0] k, input logic [7:0] b);
    expE[expN] = {k, b};
    expN++;
  endtask

  task automatic buildExp(input int op, input logic [16:0] row, input logic [9:0] col, input int cnt);
    logic [7:0] ptr;
    ptr = (col >= 10'd512) ? 8'h50 : (col >= 10'd256) ? 8'h01 : 8'h00;
    expN = 0;
    case (op)
      0: begin put(2'b10, ptr); put(2'b01, col[7:0]); put(2'b01, row[7:0]);
               put(2'b01, row[15:8]); put(2'b01, {7'b0, row[16]}); end
      1: begin put(2'b10, ptr); put(2'b10, 8'h80); put(2'b01, col[7:0]); put(2'b01, row[7:0]);
               put(2'b01, row[15:8]); put(2'b01, {7'b0, row[16]});
               for (int i = 0; i < cnt; i++) put(2'b00, wrPat(i));
               put(2'b10, 8'h10); end
      2: begin put(2'b10, 8'h60); put(2'b01, row[7:0]); put(2'b01, row[15:8]);
               put(2'b01, {7'b0, row[16]}); put(2'b10, 8'hD0); end
      3: put(2'b10, 8'h70);
      4: begin put(2'b10, 8'h90); put(2'b01, 8'h00); end
      default: put(2'b10, 8'hFF);
    endcase
  endtask

  function automatic string tagOf(input int op);
    case (op)
      0: return "R4";
      1: return "R6";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic doOp(input int op, input logic [16:0] row, input logic [9:0] col,
                      input int cnt, input bit expTo);
    int waitCyc, bad, expRd;
    bit gotDone, gotTo;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logN = 0; rdIdx = 0; gotN = 0; wIdx = 0;
    weMin = 99; weMax = 0; reMin = 99; reMax = 0; suMin = 99; suMax = 0;
    reqValid = 1'b1; reqOp = 3'(op); reqRow = row; reqCol = col; reqCount = 10'(cnt);
    @(negedge clk);
    reqValid = 1'b0;
    chk(!reqReady && !nandCeN, "R12", "busy after accept", {reqReady, nandCeN}, 0);
    gotDone = 0; gotTo = 0; waitCyc = 0;
    while (!gotDone && waitCyc < 30000) begin
      if (doneP) begin gotDone = 1; gotTo = timedOut; end
      else begin
        chk(!reqReady || waitCyc == 0, "R12", "ready before done", reqReady, 0);
        @(negedge clk);
        waitCyc++;
      end
    end
    @(negedge clk);
    chk(gotDone && reqReady, "R12", "single done then ready", {gotDone, reqReady}, 3);
    chk(gotTo == expTo, "R11", "timeout flag", gotTo, expTo);
    buildExp(op, row, col, cnt);
    bad = -1;
    for (int i = 0; i < expN; i++) if (bad < 0 && (i >= logN || logE[i] != expE[i])) bad = i;
    if (bad < 0 && logN != expN) bad = expN;
    chk(bad < 0, {"R2/", tagOf(op)}, "bus frame (first bad index, entry)", bad,
        (bad >= 0 && bad < logN && bad < expN) ? int'(expE[bad]) : expN);
    expRd = expTo ? 0 : (op == 0 || op == 4) ? cnt : (op == 3) ? 1 : 0;
    bad = (gotN != expRd) ? gotN : -1;
    for (int i = 0; i < gotN && i < expRd; i++) if (bad < 0 && gotRd[i] != rdPat(i)) bad = i;
    chk(bad < 0, op == 3 ? "R8" : "R5", "read bytes (count or bad index)", bad, expRd);
  endtask

  task automatic chkTiming(input int su, input int lo);
    int eSu, eLo;
    eSu = (su == 0) ? 1 : su;
    eLo = (lo == 0) ? 1 : lo;
    chk(weMin == eLo && weMax == eLo, "R3", "write strobe low width", weMax, eLo);
    chk(suMin == eSu && suMax == eSu, "R3", "latch setup before strobe", suMax, eSu);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(nandCeN && nandWeN && nandReN && !nandCle && !nandAle && !doneP,
        "R1", "pins in reset", {nandCeN, nandWeN, nandReN, nandCle, nandAle}, 5'b11100);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady && nandCeN && nandWeN && nandReN && !nandCle && !nandAle,
        "R1", "idle after reset", {reqReady, nandCeN, nandWeN, nandReN}, 4'b1111);

    // directed: pointer selection at the column boundaries
    doOp(0, 17'h1_2345, 10'd255, 3, 0);
    doOp(0, 17'h0_00FF, 10'd256, 2, 0);
    doOp(0, 17'h1_FFFF, 10'd511, 1, 0);
    doOp(0, 17'h0_8001, 10'd512, 4, 0);
    doOp(0, 17'h1_0000, 10'd527, 0, 0);
    doOp(1, 17'h0_4321, 10'd7, 5, 0);
    doOp(1, 17'h1_0203, 10'd520, 0, 0);
    doOp(2, 17'h1_ABCD, 10'd300, 9, 0);
    doOp(3, 17'h0, 10'd0, 7, 0);
    doOp(4, 17'h0, 10'd0, 5, 0);
    doOp(5, 17'h0, 10'd0, 0, 0);

    // directed timing (R3): slow then zero settings
    cfgSetup = 4'd3; cfgLow = 4'd4; cfgHigh = 4'd2;
    doOp(1, 17'h0_0011, 10'd2, 3, 0);
    chkTiming(3, 4);
    doOp(0, 17'h0_0022, 10'd40, 3, 0);
    chk(reMin == 4 && reMax == 4, "R3", "read strobe low width", reMax, 4);
    cfgSetup = 4'd0; cfgLow = 4'd0; cfgHigh = 4'd0;
    doOp(2, 17'h0_0033, 10'd0, 0, 0);
    chkTiming(0, 0);

    // directed timeout (R11): busy held far longer than the limit
    cfgSetup = 4'd1; cfgLow = 4'd1; cfgHigh = 4'd1;
    cfgTimeout = 16'd40; busyLen = 300;
    doOp(0, 17'h0_0044, 10'd10, 4, 1);
    repeat (400) @(negedge clk);
    cfgTimeout = 16'd4000; busyLen = 24;

    // random requests
    for (int n = 0; n < 40; n++) begin
      int op, cnt;
      op = $urandom % 6;
      cnt = $urandom % 12;
      cfgSetup = 4'($urandom % 4); cfgLow = 4'($urandom % 4); cfgHigh = 4'($urandom % 4);
      doOp(op, 17'($urandom), 10'($urandom % 528), cnt, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule